// File: doc/BRIEF.md
# Instanced Attribute Index Unit

This unit turns the 32-bit linear index of a dispatched thread into the index of the attribute element that the thread should fetch. When instancing is off the index passes through untouched. For per-vertex data under instancing the index is reduced modulo the padded vertex count, which is an odd factor (1, 3, 5, 7 or 9) times a power of two. For per-instance data it is divided by a constant. That constant is either a power of two, handled with a plain right shift, or an arbitrary value, handled with a fixed-point reciprocal multiply.

In the reciprocal case the caller supplies a 32-bit multiplier whose top bit is always taken as set. The caller also supplies a flag that selects a round-down correction and a post-shift. The unit keeps the high word of the product, then shifts it right. No pre-shift is applied to the index.

Operands enter with a valid/ready handshake and leave through a two-stage pipeline with a valid/ready handshake. Back-pressure stalls the whole pipeline.

Top module: `attr_index_unit`

## Requirements
- R1: With mode_i = 0 (linear) the output element equals the input index.
- R2: With mode_i = 1 (modulo) the output is index mod ((2·k+1)·2^shift_i), where k = extra_i for extra_i in 0..4 and k = 4 for extra_i in 5..7.
- R3: With mode_i = 2 (shift divide) the output is index >> shift_i.
- R4: With mode_i = 3 (magic divide) bit 31 of mult_i is treated as 1 whatever value it carries.
- R5: With mode_i = 3 and extra_i[0] = 0 the output is floor(index·M / 2^32) >> shift_i, where M is the effective multiplier.
- R6: With mode_i = 3 and extra_i[0] = 1 the output is floor((index+1)·M / 2^32) >> shift_i, with index+1 formed without wrapping, so index 0xFFFFFFFF is exact. Constants chosen by the round-down method give exact division by any divisor that is not a power of two.
- R7: An operand accepted at an edge, with out_ready_i high, appears with out_valid_o high two edges later. in_ready_o is high whenever out_valid_o is low or out_ready_i is high.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and elem_o stays unchanged. Results leave in the order they were accepted.
- R9: During reset out_valid_o is low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand set valid |
| in_ready_o | output | 1 | Unit can take an operand set |
| mode_i | input | 2 | 0 linear, 1 modulo, 2 shift divide, 3 magic divide |
| shift_i | input | 5 | Power-of-two exponent or post-shift |
| extra_i | input | 3 | Odd-factor selector (modulo) or round-down flag in bit 0 (magic) |
| mult_i | input | 32 | Magic multiplier, bit 31 implied set |
| index_i | input | 32 | Linear thread index |
| out_valid_o | output | 1 | Element index valid |
| out_ready_i | input | 1 | Consumer takes the element index |
| elem_o | output | 32 | Element index |

## Verification
Every mode is compared with plain integer division and modulo. Boundary indices (0, 1, divisor−1, divisor, all ones) separate off-by-one and overflow faults from gross ones, and random indices cover the carry paths.

In magic mode the bench derives its constants from real divisors. Divisors that need round-down and divisors that do not both appear, and random clearing of multiplier bit 31 tests the implied bit. A zero multiplier isolates that bit completely.

Modulo runs through every odd factor and the out-of-range selectors, with shifts of 0 and 31, to find faults in the split and recombine. Random back-pressure exercises holding and ordering, and one unstalled transfer measures the latency.

// File: rtl/attr_idx_pkg.sv
package attr_idx_pkg;
  typedef enum logic [1:0] {
    MODE_LINEAR = 2'd0,
    MODE_MODULO = 2'd1,
    MODE_SHIFT  = 2'd2,
    MODE_MAGIC  = 2'd3
  } idx_mode_e;
endpackage

// File: rtl/attr_idx_prep.sv
module attr_idx_prep #(
  parameter int IDX_W = 32
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] mul_i,
  input  logic             round_i,
  output logic [IDX_W:0]   op_o,
  output logic [IDX_W-1:0] mul_o
);
  // one extra bit keeps index+1 exact at all-ones
  assign op_o  = {1'b0, idx_i} + {{IDX_W{1'b0}}, round_i};
  assign mul_o = {1'b1, mul_i[IDX_W-2:0]};
endmodule

// File: rtl/attr_idx_magic.sv
module attr_idx_magic #(
  parameter int IDX_W = 32,
  parameter int SH_W  = $clog2(IDX_W)
) (
  input  logic [IDX_W:0]   op_i,
  input  logic [IDX_W-1:0] mul_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic [IDX_W-1:0] quo_o
);
  localparam int PROD_W = 2 * IDX_W;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] prod_hi;

  // op <= 2^IDX_W and mul < 2^IDX_W, so the product fits PROD_W
  assign prod    = PROD_W'(op_i) * PROD_W'(mul_i);
  assign prod_hi = prod >> IDX_W;
  assign quo_o   = IDX_W'(prod_hi >> shift_i);
endmodule

// File: rtl/attr_idx_odd_mod.sv
module attr_idx_odd_mod #(
  parameter int IDX_W   = 32,
  parameter int NUM_ODD = 5,
  parameter int SEL_W   = 3,
  parameter int SH_W    = $clog2(IDX_W)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [IDX_W-1:0] rem_o
);
  localparam int REM_W = $clog2(2 * NUM_ODD);

  logic [IDX_W-1:0] hi_part;
  logic [IDX_W-1:0] lo_mask;
  logic [REM_W-1:0] rems [NUM_ODD];
  logic [SEL_W-1:0] sel_c;

  assign hi_part = idx_i >> shift_i;
  assign lo_mask = ~({IDX_W{1'b1}} << shift_i);

  for (genvar g = 0; g < NUM_ODD; g++) begin : g_odd
    localparam int ODD = 2 * g + 1;
    assign rems[g] = REM_W'(hi_part % IDX_W'(ODD));
  end

  assign sel_c = (sel_i > SEL_W'(NUM_ODD - 1)) ? SEL_W'(NUM_ODD - 1) : sel_i;
  // rem <= hi, so the shifted remainder never leaves IDX_W bits
  assign rem_o = (IDX_W'(rems[sel_c]) << shift_i) | (idx_i & lo_mask);

  always_comb begin
    p_mod_le_r2: assert (rem_o <= idx_i);
  end
endmodule

// File: rtl/attr_index_unit.sv
module attr_index_unit
  import attr_idx_pkg::*;
#(
  parameter int IDX_W = 32,
  parameter int EXT_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic [1:0]               mode_i,
  input  logic [$clog2(IDX_W)-1:0] shift_i,
  input  logic [EXT_W-1:0]         extra_i,
  input  logic [IDX_W-1:0]         mult_i,
  input  logic [IDX_W-1:0]         index_i,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic [IDX_W-1:0]         elem_o
);
  localparam int SH_W = $clog2(IDX_W);

  logic             adv;
  logic             round_in;
  logic [IDX_W:0]   op_in;
  logic [IDX_W-1:0] mul_in;

  logic             v1_q;
  idx_mode_e        mode1_q;
  logic [SH_W-1:0]  sh1_q;
  logic [EXT_W-1:0] ext1_q;
  logic [IDX_W-1:0] idx1_q;
  logic [IDX_W:0]   op1_q;
  logic [IDX_W-1:0] mul1_q;

  logic [IDX_W-1:0] quo_magic;
  logic [IDX_W-1:0] rem_mod;
  logic [IDX_W-1:0] res_d;

  logic             vo_q;
  logic [IDX_W-1:0] elem_q;

  assign adv        = !vo_q || out_ready_i;
  assign in_ready_o = adv;
  assign round_in   = (idx_mode_e'(mode_i) == MODE_MAGIC) && extra_i[0];

  attr_idx_prep #(.IDX_W(IDX_W)) u_prep (
    .idx_i   (index_i),
    .mul_i   (mult_i),
    .round_i (round_in),
    .op_o    (op_in),
    .mul_o   (mul_in)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q    <= 1'b0;
      mode1_q <= MODE_LINEAR;
      sh1_q   <= '0;
      ext1_q  <= '0;
      idx1_q  <= '0;
      op1_q   <= '0;
      mul1_q  <= '0;
    end else if (adv) begin
      v1_q <= in_valid_i;
      if (in_valid_i) begin
        mode1_q <= idx_mode_e'(mode_i);
        sh1_q   <= shift_i;
        ext1_q  <= extra_i;
        idx1_q  <= index_i;
        op1_q   <= op_in;
        mul1_q  <= mul_in;
      end
    end
  end

  attr_idx_magic #(.IDX_W(IDX_W), .SH_W(SH_W)) u_magic (
    .op_i    (op1_q),
    .mul_i   (mul1_q),
    .shift_i (sh1_q),
    .quo_o   (quo_magic)
  );

  attr_idx_odd_mod #(.IDX_W(IDX_W), .NUM_ODD(5), .SEL_W(EXT_W), .SH_W(SH_W)) u_mod (
    .idx_i   (idx1_q),
    .shift_i (sh1_q),
    .sel_i   (ext1_q),
    .rem_o   (rem_mod)
  );

  always_comb begin
    unique case (mode1_q)
      MODE_LINEAR: res_d = idx1_q;
      MODE_MODULO: res_d = rem_mod;
      MODE_SHIFT:  res_d = idx1_q >> sh1_q;
      MODE_MAGIC:  res_d = quo_magic;
      default:     res_d = idx1_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vo_q   <= 1'b0;
      elem_q <= '0;
    end else if (adv) begin
      vo_q <= v1_q;
      if (v1_q) elem_q <= res_d;
    end
  end

  assign out_valid_o = vo_q;
  assign elem_o      = elem_q;

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vo_q && !out_ready_i) |=> (out_valid_o && $stable(elem_o)));

  p_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_q && adv) |=> out_valid_o);

  p_lin_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_q && adv && mode1_q == MODE_LINEAR) |=> (elem_o == $past(idx1_q)));

  p_shr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_q && adv && mode1_q == MODE_SHIFT) |=> (elem_o <= $past(idx1_q)));

  p_impl_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && adv && mode_i == 2'd3) |=> mul1_q[IDX_W-1]);

  p_magic_le_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_q && adv && mode1_q == MODE_MAGIC) |=> (elem_o <= $past(idx1_q)));
endmodule

// File: tb/sim_attr_index_unit.sv
module sim_attr_index_unit;
  timeunit 1ns;
  timeprecision 100ps;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  mode = 2'd0;
  logic [4:0]  shift = 5'd0;
  logic [2:0]  extra = 3'd0;
  logic [31:0] mult = 32'd0;
  logic [31:0] index = 32'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] elem;

  int    checks = 0;
  int    errors = 0;
  bit    stall_en = 1'b0;
  bit    done = 1'b0;
  item_t sb [$];

  always #2 clk = ~clk;

  attr_index_unit u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .mode_i      (mode),
    .shift_i     (shift),
    .extra_i     (extra),
    .mult_i      (mult),
    .index_i     (index),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .elem_o      (elem)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic send(logic [1:0] m, logic [4:0] s, logic [2:0] e,
                      logic [31:0] mu, logic [31:0] ix, logic [31:0] exp, string tag);
    item_t it;
    @(negedge clk);
    mode = m; shift = s; extra = e; mult = mu; index = ix; in_valid = 1'b1;
    out_ready = stall_en ? ($urandom_range(3) != 0) : 1'b1;
    #0.5;
    while (!in_ready) begin
      @(negedge clk);
      out_ready = stall_en ? ($urandom_range(3) != 0) : 1'b1;
      #0.5;
    end
    it.exp = exp;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle_drain();
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic void magic_for(input longint unsigned d, output logic [4:0] s,
                                    output logic [31:0] mu, output logic rd);
    int k;
    longint unsigned p, q, r, mc;
    k = 0;
    for (int b = 0; b < 32; b++) if (((d >> b) & 64'd1) != 0) k = b;
    p = 64'd1 << (k + 32);
    q = p / d;
    r = p % d;
    mc = (r == 0) ? q : q + 1;
    s = 5'(k);
    if (r <= (64'd1 << k)) begin mu = 32'(mc - 1); rd = 1'b1; end
    else begin mu = 32'(mc); rd = 1'b0; end
  endfunction

  function automatic logic [31:0] mod_exp(logic [31:0] ix, logic [4:0] s, logic [2:0] e);
    longint unsigned k, md;
    k = (e > 3'd4) ? 64'd4 : longint'(e);
    md = (2 * k + 1) << s;
    return 32'(longint'(ix) % md);
  endfunction

  // monitor: pops expected results and tracks the hold rule
  initial begin
    bit          held = 1'b0;
    logic [31:0] held_val = '0;
    item_t       it;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && !done) begin
        if (held) begin
          check("R8 valid held", {31'd0, out_valid}, 32'd1);
          check("R8 data held", elem, held_val);
        end
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            errors++;
            $display("FAIL R8 unexpected output actual=%h expected=none", elem);
          end else begin
            it = sb.pop_front();
            check(it.tag, elem, it.exp);
          end
        end
        held = out_valid && !out_ready;
        held_val = elem;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    summary();
  end

  initial begin
    logic [31:0] ix, d32, mu;
    logic [4:0]  s;
    logic        rd;
    logic [31:0] divs [12];

    repeat (3) @(negedge clk);
    check("R9 reset valid", {31'd0, out_valid}, 32'd0);
    check("R9 reset ready", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // R7 latency with no stall
    @(negedge clk);
    mode = 2'd0; index = 32'h1234_5678; in_valid = 1'b1; out_ready = 1'b1;
    #0.5;
    check("R7 ready", {31'd0, in_ready}, 32'd1);
    begin
      item_t it;
      it.exp = 32'h1234_5678; it.tag = "R7 latency data"; sb.push_back(it);
    end
    @(negedge clk);
    in_valid = 1'b0;
    #0.5;
    check("R7 not early", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    #0.5;
    check("R7 two cycles", {31'd0, out_valid}, 32'd1);
    idle_drain();

    stall_en = 1'b1;

    // R1 linear
    send(2'd0, 5'd7, 3'd5, 32'hdead_beef, 32'h0, 32'h0, "R1 linear");
    send(2'd0, 5'd0, 3'd0, 32'h0, 32'hffff_ffff, 32'hffff_ffff, "R1 linear");
    for (int i = 0; i < 10; i++) begin
      ix = $urandom;
      send(2'd0, 5'($urandom), 3'($urandom), $urandom, ix, ix, "R1 linear");
    end

    // R2 modulo
    for (int e = 0; e < 8; e++) begin
      foreach (divs[j]) divs[j] = 32'(j);
      for (int sh = 0; sh < 32; sh += 5) begin
        send(2'd1, 5'(sh), 3'(e), 32'h0, 32'hffff_ffff,
             mod_exp(32'hffff_ffff, 5'(sh), 3'(e)), "R2 modulo");
        ix = $urandom;
        send(2'd1, 5'(sh), 3'(e), 32'h0, ix, mod_exp(ix, 5'(sh), 3'(e)), "R2 modulo");
      end
      send(2'd1, 5'd31, 3'(e), 32'h0, 32'h8000_0001,
           mod_exp(32'h8000_0001, 5'd31, 3'(e)), "R2 modulo");
      send(2'd1, 5'd0, 3'(e), 32'h0, 32'd0, 32'd0, "R2 modulo");
    end
    send(2'd1, 5'd3, 3'd4, 32'h0, 32'd70, 32'd70 % 32'd72, "R2 modulo");
    send(2'd1, 5'd3, 3'd4, 32'h0, 32'd72, 32'd0, "R2 modulo");

    // R3 shift divide
    send(2'd2, 5'd0, 3'd0, 32'h0, 32'hffff_ffff, 32'hffff_ffff, "R3 shift");
    send(2'd2, 5'd31, 3'd0, 32'h0, 32'hffff_ffff, 32'd1, "R3 shift");
    for (int i = 0; i < 10; i++) begin
      ix = $urandom;
      s = 5'($urandom);
      send(2'd2, s, 3'($urandom), 32'h0, ix, ix >> s, "R3 shift");
    end

    // R4 zero multiplier: effective 2^31, quotient is index/2
    send(2'd3, 5'd0, 3'd0, 32'h0, 32'hffff_ffff, 32'h7fff_ffff, "R4 implied bit");
    send(2'd3, 5'd2, 3'd0, 32'h0, 32'd1000, 32'd125, "R4 implied bit");

    // R5 / R6 magic divide against integer division
    divs[0] = 32'd3;  divs[1] = 32'd5;  divs[2] = 32'd7;  divs[3] = 32'd10;
    divs[4] = 32'd641; divs[5] = 32'h7fff_ffff; divs[6] = 32'hffff_ffff;
    divs[7] = 32'h8000_0001; divs[8] = 32'd72; divs[9] = 32'd6;
    divs[10] = 32'd1000; divs[11] = 32'd12345;
    for (int k = 0; k < 24; k++) begin
      if (k < 12) d32 = divs[k];
      else d32 = ($urandom | 32'd1) << $urandom_range(4);
      if (d32 < 32'd3) d32 = 32'd3;
      magic_for(longint'(d32), s, mu, rd);
      for (int t = 0; t < 7; t++) begin
        bit clr;
        string tg;
        case (t)
          0: ix = 32'd0;
          1: ix = 32'd1;
          2: ix = d32 - 32'd1;
          3: ix = d32;
          4: ix = 32'hffff_ffff;
          default: ix = $urandom;
        endcase
        clr = $urandom_range(1) == 1;
        tg = rd ? "R6 magic round-down" : (clr ? "R4 magic bit31 cleared" : "R5 magic");
        send(2'd3, s, {2'b00, rd}, clr ? (mu & 32'h7fff_ffff) : mu, ix, ix / d32, tg);
      end
    end

    idle_drain();
    done = 1'b1;
    summary();
  end
endmodule